// File: doc/BRIEF.md
# Burst-Preamble Resynchronisation Detector

This block sits on the receiving end of a single-wire serial link. On that link, each data bit is a wide level followed by one narrow clock pulse, so an ordinary bit period carries a single rising edge. Each packet opens with a service period that is filled with a fast square wave. The detector watches the raw line, before any RC filtering. It counts rising edges that follow each other closely. When enough close edges have been seen, it emits a one-cycle resynchronisation pulse that clears the receiver's packet counter and shift chain before the first data bit arrives.

From the moment of detection, the block also drives a clock-enable mask. The receiver uses this mask to stop the burst edges from clocking its data chain. Each further rising edge keeps the mask high. The mask falls only after the line has been free of rising edges for the spacing limit plus one full bit period. This quiet time covers the service period during which the filtered level discharges back to zero. Recognition depends only on edge density. The block makes no attempt to measure the burst frequency.

The line input is taken to be already synchronous to `clk`. All thresholds are counted in clock cycles and set by parameters: `GAP_MAX` (50), `EDGE_MIN` (4) and `BIT_CYCLES` (250). With a 50 MHz clock, these give a spacing limit of 1 µs and a bit period of 5 µs.

Top module: `burst_resync_det`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, `resync_o` and `mask_o` are both 0. A reset applied while the mask is active drops it.
- R2: A rising edge is a sample of `line_in` at 1 whose previous sample was 0. When `EDGE_MIN` rising edges arrive in a row, each less than `GAP_MAX` cycles after the previous one, and the mask is inactive, `resync_o` goes high in the cycle after the clock edge that sampled the last of those rises.
- R3: A spacing of `GAP_MAX` cycles or more restarts the edge count at one. Single pulses spaced one bit period apart therefore never cause detection, and neither do two short runs that are separated by such a gap.
- R4: `resync_o` is high for exactly one cycle per detection.
- R5: `mask_o` rises in the same cycle as `resync_o`.
- R6: While `mask_o` is high, no further `resync_o` is produced, and every rising edge restarts the quiet count. This includes a rising edge that arrives in the very cycle the mask would otherwise have been released.
- R7: `mask_o` falls `GAP_MAX + BIT_CYCLES` cycles after the clock edge that sampled the last rising edge. It is still high one cycle earlier.
- R8: After the mask is released, the detector is armed again, and a later burst is detected in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Raw single-wire line, synchronous to clk |
| resync_o | output | 1 | One-cycle resynchronisation pulse |
| mask_o | output | 1 | High while shift clocks must be suppressed |

## Verification
Two functions can fall in the same cycle: a fresh rising edge arriving, and the quiet counter reaching its release point. The bench provokes this by placing a single rise so that it is sampled exactly `GAP_MAX + BIT_CYCLES` cycles after the last burst edge. The expected outcome is that the mask stays high and no new resync pulse appears. The mask must then fall a full hold time after that late edge. A second overlap, between a reset and an active mask, is judged by the mask being low on the first sample after the reset.

// File: rtl/burst_resync_det.sv
module burst_resync_det #(
  parameter int GAP_MAX    = 50,
  parameter int EDGE_MIN   = 4,
  parameter int BIT_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic resync_o,
  output logic mask_o
);
  localparam int HOLD = GAP_MAX + BIT_CYCLES;
  localparam int GW   = $clog2(GAP_MAX + 1);
  localparam int EW   = $clog2(EDGE_MIN + 1);
  localparam int HW   = $clog2(HOLD + 1);

  logic          line_q;
  logic [GW-1:0] gap_cnt;
  logic [EW-1:0] edge_cnt;
  logic [HW-1:0] hold_cnt;

  wire rise  = line_in & ~line_q;
  wire close = gap_cnt < GW'(GAP_MAX);
  wire fire  = rise & close & ~mask_o & (edge_cnt >= EW'(EDGE_MIN - 1));
  wire done  = mask_o & ~rise & (hold_cnt == HW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q   <= 1'b0;
      gap_cnt  <= GW'(GAP_MAX);
      edge_cnt <= '0;
      hold_cnt <= '0;
      resync_o <= 1'b0;
      mask_o   <= 1'b0;
    end else begin
      line_q   <= line_in;
      resync_o <= fire;

      if (rise)       gap_cnt <= GW'(1);
      else if (close) gap_cnt <= gap_cnt + GW'(1);

      if (rise) begin
        if (!close)                           edge_cnt <= EW'(1);
        else if (edge_cnt != EW'(EDGE_MIN))   edge_cnt <= edge_cnt + EW'(1);
      end

      if (rise || !mask_o) hold_cnt <= '0;
      else                 hold_cnt <= hold_cnt + HW'(1);

      if (fire)      mask_o <= 1'b1;
      else if (done) mask_o <= 1'b0;
    end
  end
endmodule

module burst_resync_det_chk (
  input logic clk,
  input logic rst_n,
  input logic resync_o,
  input logic mask_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!resync_o && !mask_o)); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) resync_o |=> !resync_o); // R4
  AST_MASK_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) resync_o |-> mask_o); // R5
  AST_MASK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mask_o) |-> resync_o); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n) $past(mask_o) |-> !resync_o); // R6
endmodule

bind burst_resync_det burst_resync_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resync_o(resync_o), .mask_o(mask_o)
);

// File: tb/burst_resync_det_bench.sv
`timescale 1ns/1ps
module burst_resync_det_bench;
  localparam int GAP  = 50;
  localparam int BITC = 250;
  localparam int HOLD = GAP + BITC;
  localparam int NV   = 6;
  // period, high cycles, pulses, expected detecting pulse index (-1: none)
  localparam int VEC [NV][4] = '{
    '{25,  12, 8,  3},
    '{250, 12, 6, -1},
    '{49,  24, 5,  3},
    '{50,  25, 5, -1},
    '{25,  12, 3, -1},
    '{25,  12, 4,  3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic resync_o, mask_o;
  int n_chk = 0, n_bad = 0;
  int hits, hit_idx, hit_c;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_resync_det #(.GAP_MAX(GAP), .EDGE_MIN(4), .BIT_CYCLES(BITC)) u_burst_resync_det (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .resync_o(resync_o), .mask_o(mask_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int period, input int high, input int n);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < period; c++) begin
        line_in = (c < high);
        @(negedge clk);
        if (resync_o) begin
          hits++;
          hit_idx = i;
          hit_c = c;
          chk(mask_o == 1'b1, "R5 mask with resync", int'(mask_o), 1);
        end
      end
    line_in = 1'b0;
  endtask

  task automatic idle(input int from_m, input int to_m, input bit expect_mask);
    for (int m = from_m; m <= to_m; m++) begin
      @(negedge clk);
      if (resync_o) hits++;
      if (expect_mask && m == HOLD - 1) chk(mask_o == 1'b1, "R7 mask held", int'(mask_o), 1);
      if (expect_mask && m == HOLD)     chk(mask_o == 1'b0, "R7 mask released", int'(mask_o), 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(resync_o == 1'b0 && mask_o == 1'b0, "R1 reset state", int'({resync_o, mask_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resync_o == 1'b0 && mask_o == 1'b0, "R1 after reset", int'({resync_o, mask_o}), 0);

    // R2 R3 R4 R8: table walk; later detections prove re-arming
    for (int v = 0; v < NV; v++) begin
      hits = 0; hit_idx = -1; hit_c = -1;
      send(VEC[v][0], VEC[v][1], VEC[v][2]);
      idle(VEC[v][0], HOLD + 3, VEC[v][3] >= 0);
      if (VEC[v][3] >= 0) begin
        chk(hits == 1, "R4 one pulse per burst", hits, 1);
        chk(hit_idx == VEC[v][3] && hit_c == 0, "R2 detect edge", hit_idx, VEC[v][3]);
        if (v == 2) chk(hits == 1, "R8 rearmed detect", hits, 1);
      end else begin
        chk(hits == 0, "R3 no detection", hits, 0);
        chk(mask_o == 1'b0, "R3 mask idle", int'(mask_o), 0);
      end
    end

    // R3: two short runs split by a long gap
    hits = 0;
    send(25, 12, 3);
    repeat (40) @(negedge clk);
    send(25, 12, 3);
    idle(25, HOLD + 3, 1'b0);
    chk(hits == 0, "R3 split runs", hits, 0);

    // R6: rise lands on the release cycle
    hits = 0; hit_idx = -1;
    send(25, 12, 5);
    idle(25, HOLD - 1, 1'b1);
    line_in = 1'b1;
    @(negedge clk);
    chk(mask_o == 1'b1, "R6 late edge keeps mask", int'(mask_o), 1);
    chk(resync_o == 1'b0, "R6 no retrigger", int'(resync_o), 0);
    line_in = 1'b0;
    idle(1, HOLD + 3, 1'b1);
    chk(hits == 1, "R6 single pulse", hits, 1);

    // R1: reset while masked
    send(25, 12, 4);
    chk(mask_o == 1'b1, "R1 masked before reset", int'(mask_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mask_o == 1'b0 && resync_o == 1'b0, "R1 reset drops mask", int'({resync_o, mask_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule